// File: doc/BRIEF.md
# Companded PCM to Linear Code Expander

This block turns an 8-bit companded PCM code into a sign bit and a 13-bit linear magnitude suitable for driving a binary-weighted DAC. The code carries a sign, a 3-bit chord number that selects one of eight segments, and a 4-bit step number that places the value inside the segment. The chord field is decoded into eight mutually exclusive select lines. Each output bit is then formed as an AND-OR selection among per-chord terms, so no barrel shifter sits in the data path.

The mapping follows a piecewise-linear expansion in which each chord doubles the step size of the one below it. It departs from the ideal expansion in one place. Every ideal magnitude of 1023 or more comes out one count higher, which keeps the per-bit selection logic simple at negligible accuracy cost.

An external sequencer time-shares the block between its users, so the block keeps no state of its own. The parameter `REG_OUT` optionally adds one register stage at the output. It has no states and no transitions. With `REG_OUT=1` the output register is its only storage element, and it clears on reset.

Top module: `pcm_code_expander`

## Requirements
- R1: Input field layout: `pcm_code[7]` is the sign, `pcm_code[6:4]` is the chord number c (0..7), `pcm_code[3:0]` is the step number s (0..15).
- R2: The chord field is decoded into eight select lines of which exactly one is active for every input code.
- R3: For chord 0 the magnitude is 2*s, covering 0 to 30.
- R4: For chords 1 to 4 the magnitude equals the ideal value ((2*s + 33) * 2^c) - 33.
- R5: For chords 5 to 7, where every ideal value is 1023 or more, the magnitude equals the ideal value plus one.
- R6: The sign bit is copied to `lin_sign` and has no effect on `lin_mag`.
- R7: Within a chord the magnitude rises strictly with s, and the last step of chord c is below step 0 of chord c+1.
- R8: With `REG_OUT=1` the outputs show the conversion of the code present at the previous rising clock edge, and they are zero while `rst_n` is low. With `REG_OUT=0` the outputs follow the input with no clock.
- R9: The largest magnitude is 8032, reached for chord 7 step 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| pcm_code | input | 8 | Companded code: sign, chord, step |
| lin_sign | output | 1 | Sign copied from the code |
| lin_mag | output | 13 | Linear magnitude |

## Verification
The bench builds two instances side by side. The registered instance uses `REG_OUT=1`, which brings the reset clearing and the one-cycle latency within reach. The combinational instance uses `REG_OUT=0`, which shows the same conversion appearing with no clock. Both instances are swept over all 256 codes, and each result is compared against a behavioural model of the ideal expansion with the +1 adjustment applied above 1023. Stored results then confirm that the sign has no effect on the magnitude, that the magnitude rises strictly with the step inside each chord, and that it stays ordered across chord boundaries.

// File: rtl/pcm_exp_pkg.sv
`timescale 1ns/1ps
package pcm_exp_pkg;
    localparam int CHORD_W  = 3;
    localparam int STEP_W   = 4;
    localparam int NCHORD   = 1 << CHORD_W;
    localparam int CODE_W   = 1 + CHORD_W + STEP_W;
    localparam int SIGN_POS = CODE_W - 1;
    localparam int LIN_W    = 13;
    localparam int BIAS     = (1 << (STEP_W + 1)) + 1;
    localparam int ADJ_THR  = 1023;
    localparam int MAG_MAX  = (((2 * ((1 << STEP_W) - 1)) + BIAS) << (NCHORD - 1)) - BIAS + 1;

    typedef logic [LIN_W-1:0] lin_t;

    function automatic lin_t chord_base(input int c);
        return lin_t'((BIAS << c) - BIAS);
    endfunction
endpackage

// File: rtl/pcm_chord_decode.sv
`timescale 1ns/1ps
module pcm_chord_decode
    import pcm_exp_pkg::*;
(
    input  logic [CHORD_W-1:0] chord,
    output logic [NCHORD-1:0]  lines
);
    for (genvar c = 0; c < NCHORD; c++) begin : g_line
        assign lines[c] = (chord == CHORD_W'(c));
    end
endmodule

// File: rtl/pcm_chord_terms.sv
`timescale 1ns/1ps
module pcm_chord_terms
    import pcm_exp_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    output lin_t [NCHORD-1:0]  terms
);
    for (genvar c = 0; c < NCHORD; c++) begin : g_term
        lin_t ideal;
        assign ideal    = (lin_t'(step) << (c + 1)) + chord_base(c);
        assign terms[c] = ideal + lin_t'(ideal >= lin_t'(ADJ_THR));
    end

    always_comb begin
        for (int c = 1; c < NCHORD; c++) begin
            if (!$isunknown(step))
                AST_CHORD_ORDER: assert (terms[c] > terms[c-1]); // R7
        end
    end
endmodule

// File: rtl/pcm_onehot_mux.sv
`timescale 1ns/1ps
module pcm_onehot_mux
    import pcm_exp_pkg::*;
(
    input  logic [NCHORD-1:0] lines,
    input  lin_t [NCHORD-1:0] terms,
    output lin_t              mag
);
    for (genvar b = 0; b < LIN_W; b++) begin : g_bit
        logic [NCHORD-1:0] col;
        for (genvar c = 0; c < NCHORD; c++) begin : g_col
            assign col[c] = terms[c][b];
        end
        assign mag[b] = |(lines & col);
    end

    always_comb begin
        if (!$isunknown(lines))
            AST_ONEHOT_CHORD: assert ($onehot(lines)); // R2
    end
endmodule

// File: rtl/pcm_code_expander.sv
`timescale 1ns/1ps
module pcm_code_expander
    import pcm_exp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pcm_code,
    output logic              lin_sign,
    output logic [LIN_W-1:0]  lin_mag
);
    logic [CHORD_W-1:0] chord;
    logic [STEP_W-1:0]  step;
    logic [NCHORD-1:0]  lines;
    lin_t [NCHORD-1:0]  terms;
    lin_t               mag_comb;

    assign chord = pcm_code[SIGN_POS-1 -: CHORD_W];
    assign step  = pcm_code[STEP_W-1:0];

    pcm_chord_decode u_dec (
        .chord (chord),
        .lines (lines)
    );

    pcm_chord_terms u_terms (
        .step  (step),
        .terms (terms)
    );

    pcm_onehot_mux u_mux (
        .lines (lines),
        .terms (terms),
        .mag   (mag_comb)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lin_sign <= 1'b0;
                lin_mag  <= '0;
            end else begin
                lin_sign <= pcm_code[SIGN_POS];
                lin_mag  <= mag_comb;
            end
        end

        AST_RESET_ZERO: assert property (@(posedge clk)
            !rst_n |=> (lin_mag == '0 && !lin_sign)); // R8
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign lin_sign   = pcm_code[SIGN_POS];
        assign lin_mag    = mag_comb;
    end

    always_comb begin
        if (!$isunknown(pcm_code)) begin
            AST_ODD_MIDDLE: assert (mag_comb[0] == (chord >= 3'd1 && chord <= 3'd4)); // R5
            AST_MAG_CEILING: assert (mag_comb <= lin_t'(MAG_MAX)); // R9
        end
    end
endmodule

// File: tb/pcm_code_expander_test.sv
`timescale 1ns/1ps
module pcm_code_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  code = 8'h00;
    logic        sign_r, sign_c;
    logic [12:0] mag_r, mag_c;
    int checks = 0;
    int errors = 0;
    int got[256];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_code_expander #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pcm_code(code),
        .lin_sign(sign_r), .lin_mag(mag_r));

    pcm_code_expander #(.REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .pcm_code(code),
        .lin_sign(sign_c), .lin_mag(mag_c));

    function automatic int model(input int cd);
        int c, s, v;
        c = (cd >> 4) & 7;
        s = cd & 15;
        v = ((2 * s + 33) << c) - 33;
        if (v >= 1023) v = v + 1;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int cd);
        int c;
        c = (cd >> 4) & 7;
        if (c == 0) return "R3";
        if (c <= 4) return "R4";
        return "R5";
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        code = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset mag", int'(mag_r), 0);
        check("R8 reset sign", int'(sign_r), 0);
        check("R8 comb active in reset", int'(mag_c), 8032);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            code = 8'(i);
            #1;
            check({req_of(i), " comb"}, int'(mag_c), model(i));
            check("R6 comb sign", int'(sign_c), (i >> 7) & 1);
            @(posedge clk);
            #1;
            check({req_of(i), " R8 reg"}, int'(mag_r), model(i));
            check("R6 R1 reg sign", int'(sign_r), (i >> 7) & 1);
            got[i] = int'(mag_r);
        end
        // R8: registered output holds until the next edge
        @(negedge clk);
        code = 8'h00;
        #1;
        check("R8 hold before edge", int'(mag_r), model(255));
        check("R9 max", got[127], 8032);
        for (int i = 0; i < 128; i++) begin
            check("R6 sign no effect", got[i + 128], got[i]);
        end
        for (int i = 1; i < 128; i++) begin
            checks++;
            if (got[i] <= got[i-1]) begin
                errors++;
                $display("FAIL R7 code %0d: actual %0d expected above %0d", i, got[i], got[i-1]);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule